// File: doc/BRIEF.md
# Bus-Cycle Break Comparator

This block watches the bus cycles put out by two masters, a CPU and a DMA engine, and compares each valid cycle against a break condition that software programs. The condition is made of four parts: a compare address with a per-bit ignore mask, a set of allowed access directions, a set of allowed access sizes, and a set of allowed masters. A cycle that meets all four parts is a hit.

A hit sets a sticky status flag. The flag drives an interrupt request unless the request is masked. The same hit also starts a trigger pulse on a dedicated output. The pulse lasts a programmable number of clock periods. A hit that arrives while a pulse is still running is ignored by the pulse generator, but it still sets the flag. Software writes the condition through a simple register write port, and it clears the flag by writing a one to it.

Top module: `bus_break_unit`

## Requirements
- R1: After a synchronous active-low reset, `irq` and `trig_out` are low. The control register is zero, so no direction, size or master is allowed and no bus cycle can hit.
- R2: An address compares equal when every bit whose ignore-mask bit (select 1) is 0 equals the matching bit of the compare address (select 0). Bits whose mask bit is 1 are ignored.
- R3: Control bit 0 allows read cycles (`mon_write`=0) to hit, and control bit 1 allows write cycles to hit. A direction whose bit is clear never hits.
- R4: Control bit 2 allows byte cycles (`mon_word`=0) to hit, and control bit 3 allows word cycles to hit.
- R5: Control bit 4 allows CPU cycles (`mon_dma`=0) to hit, and control bit 5 allows DMA cycles to hit.
- R6: A hit sets the status flag at the clock edge that samples it. With the mask clear, `irq` is high from the following cycle on.
- R7: A register write to select 3 with data bit 0 set clears the flag. A hit in the same cycle wins over the clear, and writing 0 to bit 0 leaves the flag unchanged.
- R8: While control bit 8 (mask) is set, `irq` stays low. The flag is still set, so `irq` goes high once the mask is cleared. The trigger pulse still runs.
- R9: Control bits 7:6 set the pulse width: 00 gives 1 cycle, 01 gives 4, 10 gives 8 and 11 gives 16. `trig_out` goes high in the cycle after the hit.
- R10: A hit while `trig_out` is high neither extends nor restarts the pulse.
- R11: A cycle with `mon_valid` low never hits.
- R12: Register writes take effect from the cycle after the write. A bus cycle in the same cycle as a write is compared against the old condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_valid | input | 1 | A bus cycle is present this clock |
| mon_addr | input | 24 | Bus cycle address |
| mon_write | input | 1 | 1 = write, 0 = read |
| mon_word | input | 1 | 1 = word access, 0 = byte access |
| mon_dma | input | 1 | 1 = DMA master, 0 = CPU master |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 ignore mask, 2 control, 3 status |
| reg_wdata | input | 32 | Register write data |
| irq | output | 1 | Interrupt request (level) |
| trig_out | output | 1 | Break trigger pulse |

## Verification
The bench aims at the pulse generator's edges. One case is a hit on the last cycle of a pulse, where a design that restarts would stretch the output. Another is back-to-back hits, which a design that reloads would extend. The flag is tested with a clear and a hit in the same cycle; a design that gives the clear priority would lose the event. The bench also tests a masked hit followed by an unmask. A design that gates the flag itself with the mask would then never raise `irq`. Single-bit selector cases and partial address masks catch a comparator that swaps the read and write bits or the CPU and DMA bits, or that inverts the sense of the mask.

// File: rtl/brk_pkg.sv
// Package: shared register selects, control field positions and the
// pulse-width decode used by the break comparator.
// Assumes: the control register fits in the low 9 bits of the write data.
package brk_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_STAT = 2'd3
    } brk_sel_e;

    localparam int CTRL_W      = 9;
    localparam int C_RD        = 0;
    localparam int C_WR        = 1;
    localparam int C_BYTE      = 2;
    localparam int C_WORD      = 3;
    localparam int C_CPU       = 4;
    localparam int C_DMA       = 5;
    localparam int C_WID_LO    = 6;
    localparam int C_IRQ_MASK  = 8;
    localparam int MAX_PULSE   = 16;

    // Decode the 2-bit width code into a pulse length in clock periods.
    function automatic int pulse_len(input logic [1:0] code);
        case (code)
            2'b00:   pulse_len = 1;
            2'b01:   pulse_len = 4;
            2'b10:   pulse_len = 8;
            default: pulse_len = MAX_PULSE;
        endcase
    endfunction

endpackage

// File: rtl/brk_regs.sv
// Module: condition and status registers.
// Holds the compare address, the ignore mask, the control word and the
// sticky hit flag. A hit has priority over a software clear.
// Assumes: ADDR_W <= DATA_W.
module brk_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_hit,
    output logic [ADDR_W-1:0] cmp_addr,
    output logic [ADDR_W-1:0] addr_mask,
    output logic [CTRL_W-1:0] ctrl,
    output logic              flag,
    output logic              clr_req
);

    // Decode a write-one-to-clear request on the status register.
    always_comb begin
        clr_req = we && (brk_sel_e'(sel) == SEL_STAT) && wdata[0];
    end

    // Load the condition registers from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_addr  <= '0;
            addr_mask <= '0;
            ctrl      <= '0;
        end else if (we) begin
            case (brk_sel_e'(sel))
                SEL_ADDR: cmp_addr  <= wdata[ADDR_W-1:0];
                SEL_MASK: addr_mask <= wdata[ADDR_W-1:0];
                SEL_CTRL: ctrl      <= wdata[CTRL_W-1:0];
                default:  ;
            endcase
        end
    end

    // Keep the sticky flag: set on a hit, cleared on request, hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_hit) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/brk_match.sv
// Module: bus-cycle comparator.
// Combinationally compares one monitored cycle with the programmed
// condition. Each qualifier is a pair of allow bits, one per alternative.
// Assumes: monitor inputs are stable around the sampling edge.
module brk_match
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              word,
    input  logic              dma,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              hit
);

    logic [ADDR_W-1:0] bit_ok;
    logic              dir_ok, size_ok, mst_ok;

    // Per-bit address compare; masked bits always pass.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
        assign bit_ok[i] = addr_mask[i] | ~(addr[i] ^ cmp_addr[i]);
    end

    // Pick the allow bit that belongs to each attribute of the cycle.
    always_comb begin
        dir_ok  = write ? ctrl[C_WR]   : ctrl[C_RD];
        size_ok = word  ? ctrl[C_WORD] : ctrl[C_BYTE];
        mst_ok  = dma   ? ctrl[C_DMA]  : ctrl[C_CPU];
        hit     = valid && (&bit_ok) && dir_ok && size_ok && mst_ok;
    end

endmodule

// File: rtl/brk_pulse.sv
// Module: trigger pulse generator.
// Loads a down-counter on a hit when idle; the output is high while the
// counter is non-zero. Hits during a running pulse are ignored.
// Assumes: width code is sampled in the cycle of the hit.
module brk_pulse
    import brk_pkg::*;
#(
    parameter int CNT_W = $clog2(MAX_PULSE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [1:0]       width_code,
    output logic [CNT_W-1:0] cnt,
    output logic             trig
);

    // Count down a running pulse, or start one on an idle hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (hit) begin
            cnt <= CNT_W'(pulse_len(width_code));
        end
    end

    // Drive the trigger while the pulse counter runs.
    always_comb begin
        trig = (cnt != '0);
    end

endmodule

// File: rtl/bus_break_unit.sv
// Module: top of the bus-cycle break comparator.
// Ties the register file, the comparator and the pulse generator together
// and gates the interrupt with the mask bit.
// Assumes: one monitored bus cycle per clock at most.
module bus_break_unit
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_valid,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic              mon_write,
    input  logic              mon_word,
    input  logic              mon_dma,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              irq,
    output logic              trig_out
);

    localparam int CNT_W = $clog2(MAX_PULSE + 1);

    logic [ADDR_W-1:0] cmp_addr, addr_mask;
    logic [CTRL_W-1:0] ctrl;
    logic              flag, clr_req, hit;
    logic [CNT_W-1:0]  pulse_cnt;

    brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .set_hit(hit), .cmp_addr(cmp_addr),
        .addr_mask(addr_mask), .ctrl(ctrl), .flag(flag), .clr_req(clr_req)
    );

    brk_match #(.ADDR_W(ADDR_W)) u_match (
        .valid(mon_valid), .addr(mon_addr), .write(mon_write),
        .word(mon_word), .dma(mon_dma), .cmp_addr(cmp_addr),
        .addr_mask(addr_mask), .ctrl(ctrl), .hit(hit)
    );

    brk_pulse #(.CNT_W(CNT_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .hit(hit),
        .width_code(ctrl[C_WID_LO +: 2]), .cnt(pulse_cnt), .trig(trig_out)
    );

    // Present the flag as an interrupt unless masked.
    always_comb begin
        irq = flag & ~ctrl[C_IRQ_MASK];
    end

endmodule

// File: rtl/brk_checker.sv
// Module: property checker for bus_break_unit, attached by bind.
// Observes the hit, flag and pulse counter alongside the top-level ports.
module brk_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mon_valid,
    input logic             hit,
    input logic             flag,
    input logic             clr_req,
    input logic [CNT_W-1:0] cnt,
    input logic             trig_out
);

    // R6: a hit leaves the flag set on the next cycle.
    a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R7: with no hit and no clear, the flag holds.
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !clr_req) |=> $stable(flag));

    // R9: an idle hit starts the pulse on the next cycle.
    a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cnt == '0) |=> trig_out);

    // R10: a running pulse only counts down, whatever hits arrive.
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R11: no hit without a valid cycle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_valid |-> !hit);

endmodule

bind bus_break_unit brk_checker #(.CNT_W(CNT_W)) i_brk_checker (
    .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .hit(hit),
    .flag(flag), .clr_req(clr_req), .cnt(pulse_cnt), .trig_out(trig_out)
);

// File: tb/test_bus_break_unit.sv
module test_bus_break_unit;

    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_valid = 1'b0;
    logic [AW-1:0] mon_addr = '0;
    logic          mon_write = 1'b0, mon_word = 1'b0, mon_dma = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          irq, trig_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model state
    logic [AW-1:0] m_addr = '0, m_mask = '0;
    logic [8:0]    m_ctrl = '0;
    bit            m_flag = 0;
    int            m_cnt = 0;

    always #2.5 clk = ~clk;

    bus_break_unit i_bus_break_unit (
        .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_addr(mon_addr),
        .mon_write(mon_write), .mon_word(mon_word), .mon_dma(mon_dma),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .irq(irq), .trig_out(trig_out)
    );

    function automatic int width_of(input logic [1:0] c);
        case (c)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic bit ref_hit(input bit v, input logic [AW-1:0] a,
                                   input bit w, input bit wd, input bit d);
        bit ok;
        ok = v && (((a ^ m_addr) & ~m_mask) == '0);
        ok = ok && (w  ? m_ctrl[1] : m_ctrl[0]);
        ok = ok && (wd ? m_ctrl[3] : m_ctrl[2]);
        ok = ok && (d  ? m_ctrl[5] : m_ctrl[4]);
        return ok;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge.
    task automatic cyc(input string tag, input bit v, input logic [AW-1:0] a,
                       input bit w, input bit wd, input bit d,
                       input bit we, input logic [1:0] sel, input logic [DW-1:0] wdat);
        bit h, clr;
        mon_valid = v; mon_addr = a; mon_write = w; mon_word = wd; mon_dma = d;
        reg_we = we; reg_sel = sel; reg_wdata = wdat;
        @(posedge clk);
        h   = ref_hit(v, a, w, wd, d);
        clr = we && sel == 2'd3 && wdat[0];
        if (m_cnt != 0) m_cnt--;
        else if (h) m_cnt = width_of(m_ctrl[7:6]);
        if (h) m_flag = 1;
        else if (clr) m_flag = 0;
        if (we) begin
            case (sel)
                2'd0: m_addr = wdat[AW-1:0];
                2'd1: m_mask = wdat[AW-1:0];
                2'd2: m_ctrl = wdat[8:0];
                default: ;
            endcase
        end
        @(negedge clk);
        check(tag, irq, m_flag && !m_ctrl[8], "irq");
        check(tag, trig_out, m_cnt != 0, "trig_out");
    endtask

    task automatic bus(input string tag, input logic [AW-1:0] a, input bit w, input bit wd, input bit d);
        cyc(tag, 1, a, w, wd, d, 0, 0, 0);
    endtask

    task automatic wr(input string tag, input logic [1:0] sel, input logic [DW-1:0] v);
        cyc(tag, 0, 0, 0, 0, 0, 1, sel, v);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and no hit with zero control
        check("R1", irq, 1'b0, "irq after reset");
        check("R1", trig_out, 1'b0, "trig after reset");
        bus("R1", 24'h000000, 0, 0, 0);
        idle("R1", 1);

        // Condition: exact address, everything allowed, width x4
        wr("R12", 2'd0, 32'h00123456);
        wr("R12", 2'd2, 32'h0000007F);
        bus("R6", 24'h123456, 0, 0, 0);
        idle("R9", 5);
        // R7: write 0 keeps, write 1 clears
        wr("R7", 2'd3, 32'h0);
        wr("R7", 2'd3, 32'h1);
        // R11: valid low, address equal
        cyc("R11", 0, 24'h123456, 0, 0, 0, 0, 0, 0);
        idle("R11", 1);
        // R2: partial mask
        wr("R2", 2'd1, 32'h0000000F);
        bus("R2", 24'h12345A, 0, 0, 0);
        idle("R2", 5);
        wr("R7", 2'd3, 32'h1);
        bus("R2", 24'h12355A, 0, 0, 0);
        idle("R2", 2);
        // R3: writes only
        wr("R3", 2'd2, 32'h0000003E);
        bus("R3", 24'h123456, 0, 0, 0);
        bus("R3", 24'h123456, 1, 0, 0);
        idle("R3", 2);
        wr("R7", 2'd3, 32'h1);
        // R4: word only
        wr("R4", 2'd2, 32'h0000003B);
        bus("R4", 24'h123456, 0, 0, 0);
        bus("R4", 24'h123456, 0, 1, 0);
        idle("R4", 2);
        wr("R7", 2'd3, 32'h1);
        // R5: DMA only
        wr("R5", 2'd2, 32'h0000002F);
        bus("R5", 24'h123456, 0, 0, 0);
        bus("R5", 24'h123456, 0, 0, 1);
        idle("R5", 2);
        // R7: clear and hit in the same cycle, hit wins
        cyc("R7", 1, 24'h123456, 0, 0, 1, 1, 2'd3, 32'h1);
        idle("R7", 1);
        wr("R7", 2'd3, 32'h1);
        // R8: masked hit, pulse still runs, unmask raises irq
        wr("R8", 2'd2, 32'h0000017F);
        bus("R8", 24'h123456, 0, 0, 0);
        idle("R8", 5);
        wr("R8", 2'd2, 32'h0000007F);
        idle("R8", 1);
        wr("R7", 2'd3, 32'h1);
        // R9: each width code
        for (int c = 0; c < 4; c++) begin
            wr("R9", 2'd2, 32'h3F | (c << 6));
            bus("R9", 24'h123456, 1, 1, 1);
            idle("R9", 18);
        end
        // R10: hits during the pulse, including its last cycle
        wr("R10", 2'd2, 32'h0000007F);
        bus("R10", 24'h123456, 0, 0, 0);
        bus("R10", 24'h123456, 0, 0, 0);
        bus("R10", 24'h123456, 0, 0, 0);
        bus("R10", 24'h123456, 0, 0, 0);
        bus("R10", 24'h123456, 0, 0, 0);
        idle("R10", 6);
        // R12: write and bus cycle in one clock use the old condition
        cyc("R12", 1, 24'h123456, 0, 0, 0, 1, 2'd2, 32'h0);
        idle("R12", 5);

        // Random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [AW-1:0] a;
            r = $urandom_range(0, 19);
            if (r == 0) wr("R2", 2'd1, $urandom() & 32'h000000FF);
            else if (r == 1) wr("R8", 2'd2, $urandom() & 32'h1FF);
            else if (r == 2) wr("R7", 2'd3, $urandom() & 32'h1);
            else if (r < 12) begin
                a = ($urandom_range(0, 1) != 0) ? (m_addr ^ (AW'($urandom()) & 24'h0000FF))
                                                : AW'($urandom());
                cyc("R6", $urandom_range(0, 3) != 0, a, 1'($urandom()), 1'($urandom()),
                    1'($urandom()), 0, 0, 0);
            end else idle("R11", 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule